// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block takes a small processor core through its power states: run, idle, ordinary sleep, and deep sleep with a short entry phase before it. The core asks for a state with a one-cycle power-save command that selects idle or sleep. A sleep command becomes a deep-sleep entry only when three conditions hold. Software must have armed the block through a write strobe. The command must arrive within a short window after that write. No re-entry hold-off may be in force. In every other case the sleep command gives ordinary sleep. The block drives the CPU clock enable, the system clock enable, a core power-down request, a one-cycle watchdog clear on idle entry, and a sticky record of which events ended deep sleep.

Each clock cycle counts as one instruction cycle. An interrupt that arrives in the same cycle as an idle or sleep command does not cancel the entry. It is kept, and it wakes the core once the entry has happened. After a deep-sleep wake, a release flag is set. Deep sleep stays blocked until software clears that flag and a short gap has passed.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset `mode_o` is 0 (run), both clock enables are 1, and `core_pd_req`, `arm_flag`, `release_flag` and `wake_cause` are 0. The `mode_o` codes are: run 0, idle 1, sleep 2, deep-sleep entry 3, deep sleep 4.
- R2: A command with `ps_sleep`=0 in run gives idle on the next cycle. In idle `cpu_clk_en` is 0 and `sys_clk_en` is 1. `wdt_clr` is 1 for exactly the first idle cycle.
- R3: In idle or sleep, any of `irq`, `wdt_to`, `mclr` or `por` returns the block to run on the next cycle, with both clocks enabled.
- R4: An `arm_wr` pulse in run sets `arm_flag` on the next cycle. The same pulse clears every bit of `wake_cause`.
- R5: A sleep command issued 1 to ARM_WIN (3) cycles after the arm write cycle, with no hold-off active, moves the block to deep-sleep entry.
- R6: If no command arrives, `arm_flag` is 1 for ARM_WIN cycles and 0 from the cycle after that. A sleep command issued after the flag has cleared gives ordinary sleep.
- R7: In sleep both clock enables are 0 and `core_pd_req` is 0.
- R8: Deep-sleep entry lasts ENTRY_CYC (2) cycles and is followed by deep sleep, where `core_pd_req` is 1. In deep sleep, `irq` and `wdt_to` have no effect.
- R9: In deep sleep, any of `por`, `mclr`, `alarm`, `ext_int0` or `dswdt_to` returns the block to run on the next cycle. On that exit, `arm_flag` is cleared and `release_flag` is set. The exit also ORs into `wake_cause` a bit for every source present in that cycle: bit0 `por`, bit1 `mclr`, bit2 `alarm`, bit3 `ext_int0`, bit4 `dswdt_to`. The bits are sticky.
- R10: A sleep command gives ordinary sleep in two cases: while `release_flag` is 1, and during the REENTRY_GAP (3) cycles after a `rel_clr` cycle. A `rel_clr` clears `release_flag` on the next cycle.
- R11: An `irq` that coincides with an idle or sleep command does not cancel the entry. The block enters that state for one cycle and then returns to run.
- R12: `arm_wr` and power-save commands have no effect outside run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one instruction cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_wr | input | 1 | Register write that sets the deep-sleep arm flag |
| rel_clr | input | 1 | Register write that clears the release flag |
| ps_valid | input | 1 | Power-save command strobe from the core |
| ps_sleep | input | 1 | Command kind: 1 sleep, 0 idle |
| irq | input | 1 | Any individually enabled interrupt |
| wdt_to | input | 1 | Ordinary watchdog time-out |
| mclr | input | 1 | External reset pin event |
| por | input | 1 | Power-on reset event |
| alarm | input | 1 | Real-time clock alarm |
| ext_int0 | input | 1 | External interrupt 0 |
| dswdt_to | input | 1 | Deep-sleep watchdog time-out |
| mode_o | output | 3 | Current power state (codes in R1) |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | System clock enable |
| core_pd_req | output | 1 | Core power-down request |
| wdt_clr | output | 1 | One-cycle clear for the ordinary watchdog |
| arm_flag | output | 1 | Deep-sleep arm flag |
| release_flag | output | 1 | Set by a deep-sleep wake, cleared by software |
| wake_cause | output | 5 | Sticky deep-sleep wake sources (bits in R9) |

## Verification
The assertions assume that every input is a synchronous level sampled on the clock edge. They do not assume the inputs are mutually exclusive, so several wake sources may arrive in the same cycle. The only assumption about software is that arm and release writes are single-cycle strobes, which the assertions do not otherwise restrict. The stimulus changes inputs only just after the falling edge and holds each strobe for one cycle. It keeps the deep-sleep wake sources quiet during the deep-entry phase, because the block does not sample them there.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    MD_RUN    = 3'd0,
    MD_IDLE   = 3'd1,
    MD_SLEEP  = 3'd2,
    MD_DS_ENT = 3'd3,
    MD_DEEP   = 3'd4
  } pm_mode_e;

  localparam int CAUSE_W = 5;
  localparam int CZ_POR   = 0;
  localparam int CZ_MCLR  = 1;
  localparam int CZ_ALARM = 2;
  localparam int CZ_EXT0  = 3;
  localparam int CZ_DSWDT = 4;
endpackage

// File: rtl/pm_arm_window.sv
module pm_arm_window #(
  parameter int WIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic take_i,
  input  logic exit_i,
  output logic arm_o,
  output logic ok_o
);
  localparam int AGE_W = $clog2(WIN + 1);

  logic             arm_q;
  logic             hold_q;
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      hold_q <= 1'b0;
      age_q  <= '0;
    end else if (exit_i) begin
      arm_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (set_i) begin
      arm_q  <= 1'b1;
      hold_q <= 1'b0;
      age_q  <= '0;
    end else if (take_i) begin
      hold_q <= 1'b1;
    end else if (arm_q && !hold_q) begin
      if (age_q == AGE_W'(WIN - 1)) arm_q <= 1'b0;
      else                          age_q <= age_q + 1'b1;
    end
  end

  assign arm_o = arm_q;
  assign ok_o  = arm_q && !hold_q;
endmodule

// File: rtl/pm_reentry_guard.sv
module pm_reentry_guard #(
  parameter int GAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic release_o,
  output logic block_o
);
  localparam int CNT_W = $clog2(GAP + 1);

  logic             rel_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_q <= 1'b0;
      cnt_q <= '0;
    end else if (set_i) begin
      rel_q <= 1'b1;
    end else if (clr_i) begin
      rel_q <= 1'b0;
      cnt_q <= CNT_W'(GAP);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign release_o = rel_q;
  assign block_o   = rel_q || (cnt_q != '0);
endmodule

// File: rtl/pm_wake_capture.sv
module pm_wake_capture #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         cap_i,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] cause_o
);
  logic [N-1:0] bits_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                  bits_q[i] <= 1'b0;
      else if (clear_i)            bits_q[i] <= 1'b0;
      else if (cap_i && src_i[i])  bits_q[i] <= 1'b1;
    end
  end

  assign cause_o = bits_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int ARM_WIN     = 3,
  parameter int REENTRY_GAP = 3,
  parameter int ENTRY_CYC   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_wr,
  input  logic               rel_clr,
  input  logic               ps_valid,
  input  logic               ps_sleep,
  input  logic               irq,
  input  logic               wdt_to,
  input  logic               mclr,
  input  logic               por,
  input  logic               alarm,
  input  logic               ext_int0,
  input  logic               dswdt_to,
  output logic [2:0]         mode_o,
  output logic               cpu_clk_en,
  output logic               sys_clk_en,
  output logic               core_pd_req,
  output logic               wdt_clr,
  output logic               arm_flag,
  output logic               release_flag,
  output logic [CAUSE_W-1:0] wake_cause
);
  localparam int ENT_W = $clog2(ENTRY_CYC + 1);

  pm_mode_e           state_q, state_n;
  logic [ENT_W-1:0]   ent_q;
  logic               pend_q;
  logic               wclr_q;
  logic               in_run, cmd, deep_ok, arm_ok, blocked;
  logic               ds_wake, lp_wake;
  logic [CAUSE_W-1:0] ds_src;

  assign in_run  = (state_q == MD_RUN);
  assign cmd     = in_run && ps_valid;
  assign deep_ok = cmd && ps_sleep && arm_ok && !blocked;

  always_comb begin
    ds_src            = '0;
    ds_src[CZ_POR]    = por;
    ds_src[CZ_MCLR]   = mclr;
    ds_src[CZ_ALARM]  = alarm;
    ds_src[CZ_EXT0]   = ext_int0;
    ds_src[CZ_DSWDT]  = dswdt_to;
  end

  assign ds_wake = (state_q == MD_DEEP) && (|ds_src);
  assign lp_wake = irq || pend_q || wdt_to || mclr || por;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      MD_RUN: begin
        if (cmd) begin
          if (deep_ok)       state_n = MD_DS_ENT;
          else if (ps_sleep) state_n = MD_SLEEP;
          else               state_n = MD_IDLE;
        end
      end
      MD_IDLE, MD_SLEEP: if (lp_wake) state_n = MD_RUN;
      MD_DS_ENT: if (ent_q == ENT_W'(ENTRY_CYC - 1)) state_n = MD_DEEP;
      MD_DEEP:   if (ds_wake) state_n = MD_RUN;
      default:   state_n = MD_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MD_RUN;
      ent_q   <= '0;
      pend_q  <= 1'b0;
      wclr_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      ent_q   <= (state_q == MD_DS_ENT) ? ent_q + 1'b1 : '0;
      if (state_n == MD_RUN)           pend_q <= 1'b0;
      else if (cmd && !deep_ok && irq) pend_q <= 1'b1;
      wclr_q  <= cmd && !ps_sleep;
    end
  end

  pm_arm_window #(.WIN(ARM_WIN)) u_arm (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (arm_wr && in_run),
    .take_i (deep_ok),
    .exit_i (ds_wake),
    .arm_o  (arm_flag),
    .ok_o   (arm_ok)
  );

  pm_reentry_guard #(.GAP(REENTRY_GAP)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (ds_wake),
    .clr_i     (rel_clr),
    .release_o (release_flag),
    .block_o   (blocked)
  );

  pm_wake_capture #(.N(CAUSE_W)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (arm_wr && in_run),
    .cap_i   (ds_wake),
    .src_i   (ds_src),
    .cause_o (wake_cause)
  );

  assign mode_o      = state_q;
  assign cpu_clk_en  = in_run;
  assign sys_clk_en  = in_run || (state_q == MD_IDLE);
  assign core_pd_req = (state_q == MD_DEEP);
  assign wdt_clr     = wclr_q;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk
  import pwr_mode_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               arm_wr,
  input logic               ps_valid,
  input logic               ps_sleep,
  input logic               irq,
  input logic               wdt_to,
  input logic               mclr,
  input logic               por,
  input logic               alarm,
  input logic               ext_int0,
  input logic               dswdt_to,
  input logic [2:0]         mode_o,
  input logic               wdt_clr,
  input logic               arm_flag,
  input logic               release_flag,
  input logic [CAUSE_W-1:0] wake_cause
);
  logic ds_any;
  assign ds_any = por || mclr || alarm || ext_int0 || dswdt_to;

  assert_arm_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && mode_o == MD_RUN) |=> (arm_flag && wake_cause == '0));

  assert_idle_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MD_RUN && ps_valid && !ps_sleep) |=> (mode_o == MD_IDLE && wdt_clr));

  assert_lp_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == MD_IDLE || mode_o == MD_SLEEP) && (irq || wdt_to || mclr || por))
      |=> mode_o == MD_RUN);

  assert_deep_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MD_DEEP && !ds_any) |=> mode_o == MD_DEEP);

  assert_deep_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MD_DEEP && ds_any) |=> (mode_o == MD_RUN && !arm_flag && release_flag));

  assert_cause_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != MD_DEEP && !(arm_wr && mode_o == MD_RUN)) |=> $stable(wake_cause));

  assert_release_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (release_flag && mode_o == MD_RUN && ps_valid) |=> mode_o != MD_DS_ENT);
endmodule

bind pwr_mode_ctrl pwr_mode_chk u_chk (.*);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_wr = 0, rel_clr = 0, ps_valid = 0, ps_sleep = 0;
  logic irq = 0, wdt_to = 0, mclr = 0, por = 0, alarm = 0, ext_int0 = 0, dswdt_to = 0;
  logic [2:0] mode_o;
  logic cpu_clk_en, sys_clk_en, core_pd_req, wdt_clr, arm_flag, release_flag;
  logic [4:0] wake_cause;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  localparam int RUN = 0, IDLE = 1, SLP = 2, DSE = 3, DEEP = 4;

  always #2 clk = ~clk;

  pwr_mode_ctrl u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 mode", mode_o, RUN);
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 sys_clk_en", sys_clk_en, 1);
    chk("R1 core_pd_req", core_pd_req, 0);
    chk("R1 arm_flag", arm_flag, 0);
    chk("R1 release_flag", release_flag, 0);
    chk("R1 wake_cause", wake_cause, 0);
  endtask

  task automatic t_idle;
    ps_valid = 1; ps_sleep = 0; tick; ps_valid = 0;
    chk("R2 idle mode", mode_o, IDLE);
    chk("R2 idle cpu clk", cpu_clk_en, 0);
    chk("R2 idle sys clk", sys_clk_en, 1);
    chk("R2 wdt_clr first cycle", wdt_clr, 1);
    tick;
    chk("R2 still idle", mode_o, IDLE);
    chk("R2 wdt_clr one cycle", wdt_clr, 0);
    wdt_to = 1; tick; wdt_to = 0;
    chk("R3 wdt wake idle", mode_o, RUN);
    chk("R3 cpu clk back", cpu_clk_en, 1);
  endtask

  task automatic t_sleep;
    ps_valid = 1; ps_sleep = 1; tick; ps_valid = 0;
    chk("R6 unarmed sleep", mode_o, SLP);
    chk("R7 cpu clk", cpu_clk_en, 0);
    chk("R7 sys clk", sys_clk_en, 0);
    chk("R7 no pd", core_pd_req, 0);
    arm_wr = 1; tick; arm_wr = 0;
    chk("R12 arm ignored in sleep", arm_flag, 0);
    ps_valid = 1; tick; ps_valid = 0;
    chk("R12 cmd ignored in sleep", mode_o, SLP);
    mclr = 1; tick; mclr = 0;
    chk("R3 mclr wake sleep", mode_o, RUN);
  endtask

  task automatic t_defer;
    ps_valid = 1; ps_sleep = 0; irq = 1; tick; ps_valid = 0; irq = 0;
    chk("R11 idle entered despite irq", mode_o, IDLE);
    tick;
    chk("R11 deferred irq wakes idle", mode_o, RUN);
    ps_valid = 1; ps_sleep = 1; irq = 1; tick; ps_valid = 0; irq = 0;
    chk("R11 sleep entered despite irq", mode_o, SLP);
    tick;
    chk("R11 deferred irq wakes sleep", mode_o, RUN);
  endtask

  task automatic t_expire;
    arm_wr = 1; tick; arm_wr = 0;
    chk("R4 arm set", arm_flag, 1);
    tick; tick;
    chk("R6 arm in last window cycle", arm_flag, 1);
    tick;
    chk("R6 arm expired", arm_flag, 0);
    ps_valid = 1; ps_sleep = 1; tick; ps_valid = 0;
    chk("R6 late command gives sleep", mode_o, SLP);
    por = 1; tick; por = 0;
    chk("R3 por wakes sleep", mode_o, RUN);
  endtask

  task automatic t_deep(input int k, input logic [4:0] src);
    arm_wr = 1; tick; arm_wr = 0;
    repeat (k - 1) tick;
    ps_valid = 1; ps_sleep = 1; tick; ps_valid = 0;
    chk("R5 deep entry", mode_o, DSE);
    chk("R5 entry cpu clk off", cpu_clk_en, 0);
    tick;
    chk("R8 entry lasts", mode_o, DSE);
    tick;
    chk("R8 deep reached", mode_o, DEEP);
    chk("R8 pd request", core_pd_req, 1);
    irq = 1; wdt_to = 1; tick; irq = 0; wdt_to = 0;
    chk("R8 irq/wdt ignored", mode_o, DEEP);
    ps_valid = 1; tick; ps_valid = 0;
    chk("R12 cmd ignored in deep", mode_o, DEEP);
    {dswdt_to, ext_int0, alarm, mclr, por} = src; tick;
    {dswdt_to, ext_int0, alarm, mclr, por} = '0;
    chk("R9 deep exit", mode_o, RUN);
    chk("R9 cause bits", wake_cause, src);
    chk("R9 arm cleared", arm_flag, 0);
    chk("R9 release set", release_flag, 1);
    tick;
    chk("R9 cause sticky", wake_cause, src);
  endtask

  task automatic t_block;
    arm_wr = 1; tick; arm_wr = 0;
    chk("R4 arm clears cause", wake_cause, 0);
    ps_valid = 1; ps_sleep = 1; tick; ps_valid = 0;
    chk("R10 release blocks deep", mode_o, SLP);
    irq = 1; tick; irq = 0;
    chk("R3 irq wakes sleep", mode_o, RUN);
    repeat (3) tick;
    rel_clr = 1; tick; rel_clr = 0;
    chk("R10 release cleared", release_flag, 0);
    arm_wr = 1; tick; arm_wr = 0;
    tick;
    ps_valid = 1; ps_sleep = 1; tick; ps_valid = 0;
    chk("R10 gap blocks deep", mode_o, SLP);
    irq = 1; tick; irq = 0;
    repeat (3) tick;
    rel_clr = 1; tick; rel_clr = 0;
    arm_wr = 1; tick; arm_wr = 0;
    tick; tick;
    ps_valid = 1; ps_sleep = 1; tick; ps_valid = 0;
    chk("R10 deep after gap", mode_o, DSE);
    tick; tick;
    chk("R8 deep reached again", mode_o, DEEP);
    dswdt_to = 1; tick; dswdt_to = 0;
    chk("R9 dswdt wake", mode_o, RUN);
    chk("R9 dswdt cause", wake_cause, 5'b10000);
  endtask

  initial begin
    repeat (3) tick;
    rst_n = 1;
    tick;
    t_reset;
    t_idle;
    t_sleep;
    t_defer;
    t_expire;
    t_deep(1, 5'b01100);
    rel_clr = 1; tick; rel_clr = 0;
    repeat (4) tick;
    t_deep(3, 5'b00011);
    t_block;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule